// File: doc/BRIEF.md
# Positive-Weight Rank Classifier

This block turns a word of binary inputs into a single yes/no decision. It forms seven weighted sums of the inputs, using stored coefficients that are nonnegative integers, so the sums are built from additions alone. Six of the sums act as comparison levels. The seventh, the candidate sum, is ranked against them. The decision is 1 when the candidate is greater than or equal to at least K of the six comparison sums, where K is a stored rank threshold. No sum is ever compared against a fixed constant.

The 56 coefficients and the threshold are written through a simple address/data/write-enable port. An input word is offered with a one-cycle valid strobe, and the decision appears two cycles later with its own strobe. The first cycle forms the sums and the second makes the rank decision. Inputs may arrive on consecutive cycles.

A small occupancy state machine tracks the two pipeline stages. Its states are PIPE_EMPTY (no stage busy), PIPE_HEAD (only the sum stage busy), PIPE_FULL (both stages busy) and PIPE_TAIL (only the decision stage busy). It has the following transitions:
- From PIPE_EMPTY or PIPE_TAIL, an input strobe moves it to PIPE_HEAD; with no strobe it moves to PIPE_EMPTY.
- From PIPE_HEAD or PIPE_FULL, an input strobe moves it to PIPE_FULL; with no strobe it moves to PIPE_TAIL.

The threshold in force is captured together with the input, so a configuration write never changes a decision that is already in flight. A constant input bit held at 1 serves as a bias term, which lets weight sets realise Boolean functions such as 3-bit parity.

Top module: `posw_rank_classifier`

## Requirements
- R1: While reset is low and after its release, out_valid and out_class are 0, every coefficient is 0 and the threshold is 0. An input sent in this state therefore gives a decision of 1, because all seven sums tie.
- R2: Sum s (s = 0..6) equals the sum, over input bits i = 0..7, of in_bits[i] times coefficient w[s][i]. Coefficients are unsigned 8-bit values, and an all-zero input gives all-zero sums.
- R3: Sum 6 is the candidate. out_class = 1 exactly when the number of indices j in 0..5 with S6 >= S_j is at least the threshold K. A tie counts in favour of the candidate.
- R4: For an input strobe sampled in clock cycle t, out_valid is high in cycle t+2, exactly once. Strobes on consecutive cycles give results on consecutive cycles, in input order.
- R5: A write to address s*8+i (s = 0..6, i = 0..7) sets w[s][i] to cfg_wdata. Address 56 sets K to cfg_wdata[2:0]. Addresses 57 to 63 change nothing.
- R6: A configuration write sampled in the same cycle as an input strobe, or in any later cycle, does not affect that input's decision. It applies from the next input onward.
- R7: out_class is 0 in every cycle in which out_valid is 0.
- R8: With K = 0 every decision is 1. With K = 7 every decision is 0.
- R9: Sums do not wrap. With all coefficients 255 and all inputs 1, every sum equals 2040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration address (coefficient slot or threshold) |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Input word strobe |
| in_bits | input | 8 | Binary input word |
| out_valid | output | 1 | Decision strobe, two cycles after in_valid |
| out_class | output | 1 | Classification result, 0 when out_valid is 0 |

## Verification
On every cycle, the embedded properties check the occupancy hand-off from the sum stage to the decision stage, that out_class stays quiet when no decision is presented, that K = 0 and K = 7 force their fixed decisions, and that an all-zero input yields all-zero sums. Only the bench scenarios can show the following:
- the arithmetic of the sums and the ranking with ties;
- the full-scale case without wrap;
- the address decoding, including the ignored addresses;
- the exact latency in cycles;
- that a write landing with or after an input leaves that input's decision alone.

For this the bench loads a 3-bit parity weight set with a bias input and sweeps all eight combinations. It also runs a long stream of random coefficients and inputs.

// File: rtl/wta_pkg.sv
package wta_pkg;

    // Occupancy of the two pipeline stages (sum stage, decision stage)
    typedef enum logic [1:0] {
        PIPE_EMPTY = 2'd0,
        PIPE_HEAD  = 2'd1,
        PIPE_FULL  = 2'd2,
        PIPE_TAIL  = 2'd3
    } pipe_state_t;

    // Bits needed to hold n_in terms of w_bits each without wrap
    function automatic int unsigned sum_bits_needed(input int unsigned n_in,
                                                    input int unsigned w_bits);
        return $clog2(n_in * ((1 << w_bits) - 1) + 1);
    endfunction

endpackage

// File: rtl/wta_pipe_ctrl.sv
module wta_pipe_ctrl
    import wta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic s1_occ,
    output logic s2_occ
);

    pipe_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIPE_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIPE_EMPTY: state_d = in_valid ? PIPE_HEAD : PIPE_EMPTY;
            PIPE_HEAD:  state_d = in_valid ? PIPE_FULL : PIPE_TAIL;
            PIPE_FULL:  state_d = in_valid ? PIPE_FULL : PIPE_TAIL;
            PIPE_TAIL:  state_d = in_valid ? PIPE_HEAD : PIPE_EMPTY;
            default:    state_d = PIPE_EMPTY;
        endcase
    end

    // Stage occupancy outputs
    always_comb begin
        s1_occ = 1'b0;
        s2_occ = 1'b0;
        unique case (state_q)
            PIPE_EMPTY: begin s1_occ = 1'b0; s2_occ = 1'b0; end
            PIPE_HEAD:  begin s1_occ = 1'b1; s2_occ = 1'b0; end
            PIPE_FULL:  begin s1_occ = 1'b1; s2_occ = 1'b1; end
            PIPE_TAIL:  begin s1_occ = 1'b0; s2_occ = 1'b1; end
            default:    begin s1_occ = 1'b0; s2_occ = 1'b0; end
        endcase
    end

    // R4
    lat_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_occ);

    // R4
    lat_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_occ |=> s2_occ);

    // R4
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_occ |=> !s2_occ);

endmodule

// File: rtl/wta_weight_bank.sv
module wta_weight_bank #(
    parameter int unsigned NUM_IN    = 8,
    parameter int unsigned NUM_SUMS  = 7,
    parameter int unsigned W_BITS    = 8,
    parameter int unsigned CNT_BITS  = 3,
    parameter int unsigned ADDR_BITS = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [ADDR_BITS-1:0]               cfg_addr,
    input  logic [W_BITS-1:0]                  cfg_wdata,
    output logic [NUM_SUMS*NUM_IN*W_BITS-1:0]  weights_flat,
    output logic [CNT_BITS-1:0]                thr_live
);

    localparam int unsigned THR_ADDR = NUM_SUMS * NUM_IN;

    // One coefficient register per (sum, input) slot
    for (genvar s = 0; s < NUM_SUMS; s++) begin : g_sum
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            localparam int unsigned SLOT = s * NUM_IN + i;
            logic [W_BITS-1:0] coef_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    coef_q <= '0;
                else if (cfg_we && cfg_addr == ADDR_BITS'(SLOT))
                    coef_q <= cfg_wdata;
            end
            assign weights_flat[SLOT*W_BITS +: W_BITS] = coef_q;
        end
    end

    // Rank threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_live <= '0;
        else if (cfg_we && cfg_addr == ADDR_BITS'(THR_ADDR))
            thr_live <= cfg_wdata[CNT_BITS-1:0];
    end

endmodule

// File: rtl/wta_sum_stage.sv
module wta_sum_stage #(
    parameter int unsigned NUM_IN   = 8,
    parameter int unsigned NUM_SUMS = 7,
    parameter int unsigned W_BITS   = 8,
    parameter int unsigned SUM_BITS = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [NUM_IN-1:0]                  bits,
    input  logic [NUM_SUMS*NUM_IN*W_BITS-1:0]  weights_flat,
    output logic [NUM_SUMS*SUM_BITS-1:0]       sums_flat
);

    for (genvar s = 0; s < NUM_SUMS; s++) begin : g_sum
        logic [SUM_BITS-1:0] acc;
        logic [SUM_BITS-1:0] sum_q;

        // Gated additions only: each set input bit adds its coefficient
        always_comb begin
            acc = '0;
            for (int i = 0; i < NUM_IN; i++) begin
                if (bits[i])
                    acc = acc + SUM_BITS'(weights_flat[(s*NUM_IN+i)*W_BITS +: W_BITS]);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    sum_q <= '0;
            else if (load) sum_q <= acc;
        end

        assign sums_flat[s*SUM_BITS +: SUM_BITS] = sum_q;

        // R2
        zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load && bits == '0) |=> (sum_q == '0));
    end

endmodule

// File: rtl/wta_rank_stage.sv
module wta_rank_stage #(
    parameter int unsigned NUM_CMP  = 6,
    parameter int unsigned SUM_BITS = 12,
    parameter int unsigned CNT_BITS = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [(NUM_CMP+1)*SUM_BITS-1:0]   sums_flat,
    input  logic [CNT_BITS-1:0]               thr,
    output logic                              class_q
);

    localparam int unsigned CAND = NUM_CMP;

    logic [SUM_BITS-1:0] cand;
    logic [CNT_BITS-1:0] beaten;
    logic                decide;

    // Count comparison sums that the candidate reaches or exceeds
    always_comb begin
        cand   = sums_flat[CAND*SUM_BITS +: SUM_BITS];
        beaten = '0;
        for (int j = 0; j < NUM_CMP; j++) begin
            if (cand >= sums_flat[j*SUM_BITS +: SUM_BITS])
                beaten = beaten + CNT_BITS'(1);
        end
        decide = (beaten >= thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) class_q <= 1'b0;
        else        class_q <= load ? decide : 1'b0;
    end

    // R8
    thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && thr == '0) |=> class_q);

    // R8
    thr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && thr > CNT_BITS'(NUM_CMP)) |=> !class_q);

endmodule

// File: rtl/posw_rank_classifier.sv
module posw_rank_classifier #(
    parameter int unsigned NUM_IN   = 8,
    parameter int unsigned NUM_CMP  = 6,
    parameter int unsigned W_BITS   = 8,
    parameter int unsigned SUM_BITS = 12,
    localparam int unsigned NUM_SUMS  = NUM_CMP + 1,
    localparam int unsigned CNT_BITS  = $clog2(NUM_CMP + 2),
    localparam int unsigned ADDR_BITS = $clog2(NUM_SUMS * NUM_IN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_BITS-1:0] cfg_addr,
    input  logic [W_BITS-1:0]    cfg_wdata,
    input  logic                 in_valid,
    input  logic [NUM_IN-1:0]    in_bits,
    output logic                 out_valid,
    output logic                 out_class
);

    localparam int unsigned SUM_NEED = wta_pkg::sum_bits_needed(NUM_IN, W_BITS);

    logic [NUM_SUMS*NUM_IN*W_BITS-1:0] weights_flat;
    logic [NUM_SUMS*SUM_BITS-1:0]      sums_flat;
    logic [CNT_BITS-1:0]               thr_live;
    logic [CNT_BITS-1:0]               thr_s1;
    logic                              s1_occ;
    logic                              s2_occ;
    logic                              class_q;

    wta_pipe_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .s1_occ   (s1_occ),
        .s2_occ   (s2_occ)
    );

    wta_weight_bank #(
        .NUM_IN    (NUM_IN),
        .NUM_SUMS  (NUM_SUMS),
        .W_BITS    (W_BITS),
        .CNT_BITS  (CNT_BITS),
        .ADDR_BITS (ADDR_BITS)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .weights_flat (weights_flat),
        .thr_live     (thr_live)
    );

    wta_sum_stage #(
        .NUM_IN   (NUM_IN),
        .NUM_SUMS (NUM_SUMS),
        .W_BITS   (W_BITS),
        .SUM_BITS (SUM_BITS)
    ) u_sums (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (in_valid),
        .bits         (in_bits),
        .weights_flat (weights_flat),
        .sums_flat    (sums_flat)
    );

    // Threshold travels with its input so later writes cannot reach it
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_s1 <= '0;
        else if (in_valid) thr_s1 <= thr_live;
    end

    wta_rank_stage #(
        .NUM_CMP  (NUM_CMP),
        .SUM_BITS (SUM_BITS),
        .CNT_BITS (CNT_BITS)
    ) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (s1_occ),
        .sums_flat (sums_flat),
        .thr       (thr_s1),
        .class_q   (class_q)
    );

    assign out_valid = s2_occ;
    assign out_class = class_q;

    // R7
    class_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_class);

    // R9
    sum_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_BITS >= SUM_NEED);

endmodule

// File: tb/tb_posw_rank_classifier.sv
module tb_posw_rank_classifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_bits = '0;
    logic       out_valid;
    logic       out_class;

    always #5 clk = ~clk;

    posw_rank_classifier dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_class (out_class)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Shadow configuration, updated from R5 decoding
    int sw [7][8];
    int sthr = 0;

    // Scoreboard
    int    q_exp [$];
    int    q_due [$];
    string q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Expected decision from R2/R3
    function automatic int model(input logic [7:0] b);
        int s [7];
        int cnt;
        for (int k = 0; k < 7; k++) begin
            s[k] = 0;
            for (int i = 0; i < 8; i++)
                if (b[i]) s[k] += sw[k][i];
        end
        cnt = 0;
        for (int j = 0; j < 6; j++)
            if (s[6] >= s[j]) cnt++;
        return (cnt >= sthr) ? 1 : 0;
    endfunction

    function automatic void shadow_write(input int a, input int d);
        if (a < 56)       sw[a/8][a%8] = d;
        else if (a == 56) sthr = d & 7;
    endfunction

    task automatic push(input int e, input string tag);
        q_exp.push_back(e);
        q_due.push_back(cyc + 2);
        q_tag.push_back(tag);
    endtask

    task automatic send(input logic [7:0] b, input int e, input string tag);
        @(negedge clk);
        cfg_we   = 1'b0;
        in_valid = 1'b1;
        in_bits  = b;
        push(e, tag);
    endtask

    task automatic send_model(input logic [7:0] b, input string tag);
        send(b, model(b), tag);
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 6'(a);
        cfg_wdata = 8'(d);
        shadow_write(a, d);
    endtask

    // Input and write in the same cycle (R6)
    task automatic send_and_write(input logic [7:0] b, input int e, input string tag,
                                  input int a, input int d);
        @(negedge clk);
        in_valid  = 1'b1;
        in_bits   = b;
        cfg_we    = 1'b1;
        cfg_addr  = 6'(a);
        cfg_wdata = 8'(d);
        push(e, tag);
        shadow_write(a, d);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we   = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic clear_weights();
        for (int a = 0; a < 56; a++) cfg_write(a, 0);
    endtask

    // Parity of bits 0..2 with bit 7 as bias, K = 2
    task automatic load_parity();
        clear_weights();
        cfg_write(0*8+7, 14);
        cfg_write(1*8+0, 8); cfg_write(1*8+1, 8); cfg_write(1*8+2, 8);
        cfg_write(1*8+7, 6);
        cfg_write(2*8+7, 22);
        cfg_write(3*8+7, 255); cfg_write(4*8+7, 255); cfg_write(5*8+7, 255);
        cfg_write(6*8+0, 4); cfg_write(6*8+1, 4); cfg_write(6*8+2, 4);
        cfg_write(6*8+7, 10);
        cfg_write(56, 8'hFA);  // R5: only bits [2:0] = 2 land in K
    endtask

    task automatic parity_sweep(input string tag);
        for (int c = 0; c < 8; c++) begin
            logic [7:0] b;
            b = {1'b1, 4'($urandom_range(0, 15)), 3'(c)};
            send(b, (^b[2:0]) ? 1 : 0, tag);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check("R4 unexpected out_valid", 1, 0);
                end else begin
                    int e, d;
                    string t;
                    e = q_exp.pop_front();
                    d = q_due.pop_front();
                    t = q_tag.pop_front();
                    check("R4 latency cycle", cyc, d);
                    check(t, out_class, e);
                end
            end else begin
                check("R7 class quiet when idle", out_class, 0);
                if (q_due.size() != 0 && q_due[0] <= cyc)
                    check("R4 missing result", 0, 1);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 7; s++)
            for (int i = 0; i < 8; i++) sw[s][i] = 0;
        void'($urandom(17));

        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 out_class in reset", out_class, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);

        // R1: zero coefficients, K = 0 -> all sums tie -> 1
        send(8'hA5, 1, "R1 zero weights decision");
        idle(3);

        // R3: parity via rank test, back-to-back inputs (R4)
        load_parity();
        parity_sweep("R3 parity result");
        idle(3);

        // R5: unused addresses change nothing
        for (int a = 57; a < 64; a++) cfg_write(a, 8'h00);
        parity_sweep("R5 ignored address parity result");
        idle(3);

        // R6: write in the same cycle as the input does not touch it
        send_and_write(8'h81, 1, "R6 same-cycle write result", 56, 7);
        send(8'h81, 0, "R8 K=7 result");
        // R6: write while an input is in flight
        send(8'h83, 0, "R6 in-flight base result");
        cfg_write(56, 2);
        send(8'h83, 0, "R6 new K applied result");
        send(8'h87, 1, "R6 new K parity result");
        idle(3);

        // R8: K = 0 forces 1
        cfg_write(56, 0);
        for (int k = 0; k < 6; k++) send($urandom_range(0, 255), 1, "R8 K=0 result");
        idle(3);

        // R9 and R3 ties: all coefficients 255, all inputs 1
        for (int a = 0; a < 56; a++) cfg_write(a, 255);
        cfg_write(56, 6);
        send(8'hFF, 1, "R9 full scale tie result");
        cfg_write(48, 254);
        send(8'hFF, 0, "R9 candidate one below result");
        cfg_write(56, 0);
        send(8'hFF, 1, "R9 K=0 result");
        cfg_write(48, 255);
        cfg_write(0, 254);
        cfg_write(56, 1);
        send(8'hFF, 1, "R3 beats one result");
        cfg_write(56, 2);
        send(8'hFF, 1, "R3 ties count result");
        idle(3);

        // R2: random coefficients, thresholds and inputs
        for (int k = 0; k < 300; k++) begin
            if (k % 30 == 0) begin
                for (int w = 0; w < 12; w++)
                    cfg_write($urandom_range(0, 55), $urandom_range(0, 255));
                cfg_write(56, $urandom_range(0, 6));
            end
            send_model($urandom_range(0, 255), "R2 random sums result");
        end
        idle(4);

        check("R4 scoreboard drained", q_exp.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule